// File: doc/BRIEF.md
# Configurable Chip-Address and Lock Register

This block keeps the non-volatile 8-bit chip-address register of a serial memory target, together with the permanent lock flag of its identification page. The protocol engine sends it register-space requests: reads of the chip-address register or of the identification-page lock status, writes to the chip-address register, and the one-way lock command for the identification page. The block drives the three chip-address bits that the select-code comparator uses. For every write request it returns either a one-cycle start pulse, which goes to the write-cycle timer, or a one-cycle refusal flag.

An accepted write is held as pending. It changes the visible state only in the cycle after the timer reports completion. A write is refused in four cases: the register's own lock bit is set, the lock flag is already set (for the lock command), the hardware write-control input is high, or an earlier accepted write is still pending. The power-on reset loads the factory contents. By default this is address 000, unlocked. A parameter selects a variant that is preset to a chosen address with the lock bit already set. A separate soft reset clears only transient state and leaves the stored contents untouched.

Top module: `cda_lock_reg`

## Requirements
- R1: The power-on reset (`rst_n` low) loads chip_addr=000, cfg_locked=0 and id_locked=0. With PRESET_EN=1 it loads chip_addr=PRESET_ADDR and cfg_locked=1.
- R2: A read with req_target=0 sets rsp_valid one cycle later, with rsp_data = {4'b0000, chip_addr[2:0], cfg_locked}: address in bits 3:1 and the lock bit in bit 0.
- R3: An accepted write with req_target=0 raises wr_start one cycle after the request. chip_addr and cfg_locked keep their old values until cycle_done is sampled. They then take cfg_wdata[3:1] and cfg_wdata[0] in the following cycle.
- R4: While cfg_locked is 1, every write with req_target=0 raises wr_nack and leaves chip_addr and cfg_locked unchanged. cfg_locked never returns to 0 except through the power-on reset.
- R5: While wc_in is 1, every write request to either target raises wr_nack and changes no state.
- R6: A lock command (write with req_target=1) is accepted when id_locked=0 and wc_in=0. It raises wr_start, and id_locked becomes 1 in the cycle after cycle_done.
- R7: A lock command issued while id_locked=1 raises wr_nack. id_locked never falls except through the power-on reset.
- R8: A read with req_target=1 returns rsp_data = {7'b0, id_locked} one cycle later.
- R9: A write request made while an accepted write is waiting for cycle_done raises wr_nack.
- R10: The soft reset (`soft_rst_n` low) keeps chip_addr, cfg_locked and id_locked. It discards a pending write, so a later cycle_done commits nothing.
- R11: cycle_done with no write pending changes nothing.
- R12: Each write request yields exactly one of wr_start or wr_nack, never both. A read request yields neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; loads factory contents |
| soft_rst_n | input | 1 | Synchronous active-low soft reset; clears transient state only |
| req_valid | input | 1 | Register-space request strobe, one cycle per request |
| req_write | input | 1 | 1 = write or lock command, 0 = read |
| req_target | input | 1 | 0 = chip-address register, 1 = identification-page lock |
| cfg_wdata | input | 4 | Low nibble of the data byte: bits 3:1 address, bit 0 lock |
| wc_in | input | 1 | Hardware write-control, high inhibits all writes |
| cycle_done | input | 1 | Write-cycle timer completion pulse |
| wr_start | output | 1 | One-cycle pulse: write accepted, start the write cycle |
| wr_nack | output | 1 | One-cycle pulse: write refused |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data byte |
| chip_addr | output | 3 | Chip-address bits for select-code matching |
| cfg_locked | output | 1 | Chip-address register lock bit |
| id_locked | output | 1 | Identification-page permanent lock flag |

## Verification
The assertions assume the protocol engine raises req_valid for single cycles only. They also assume that wc_in and cycle_done follow the clock, and that the power-on reset is applied before the first request. The refusal properties require the soft reset to be inactive in the request cycle, because a soft reset swallows requests. The bench drives every input on the falling edge. It sends isolated one-cycle requests and gives completion pulses only as separate events. It also never asks for a read in the cycle a pending write commits, so each response reflects a settled state.

// File: rtl/cda_lock_reg.sv
module cda_lock_reg #(
  parameter bit         PRESET_EN   = 1'b0,
  parameter logic [2:0] PRESET_ADDR = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_target,
  input  logic [3:0] cfg_wdata,
  input  logic       wc_in,
  input  logic       cycle_done,
  output logic       wr_start,
  output logic       wr_nack,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic [2:0] chip_addr,
  output logic       cfg_locked,
  output logic       id_locked
);

  logic [2:0] addr_q;
  logic       cfg_lock_q, id_lock_q;
  logic       pend_q, pend_tgt_q;
  logic [3:0] pend_val_q;
  logic       start_q, nack_q, rsp_v_q;
  logic [7:0] rsp_q;

  logic wr_req, refuse, accept, commit;

  assign wr_req = req_valid & req_write;
  assign refuse = wc_in | pend_q | (req_target ? id_lock_q : cfg_lock_q);
  assign accept = wr_req & ~refuse;
  assign commit = pend_q & cycle_done & soft_rst_n;

  // contents that survive the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= PRESET_EN ? PRESET_ADDR : 3'b000;
      cfg_lock_q <= PRESET_EN;
      id_lock_q  <= 1'b0;
    end else if (commit) begin
      if (pend_tgt_q) id_lock_q <= 1'b1;
      else {addr_q, cfg_lock_q} <= pend_val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_tgt_q <= 1'b0;
      pend_val_q <= 4'h0;
      start_q    <= 1'b0;
      nack_q     <= 1'b0;
      rsp_v_q    <= 1'b0;
      rsp_q      <= 8'h00;
    end else if (!soft_rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      nack_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      start_q <= accept;
      nack_q  <= wr_req & refuse;
      rsp_v_q <= req_valid & ~req_write;
      rsp_q   <= req_target ? {7'b0, id_lock_q} : {4'b0, addr_q, cfg_lock_q};
      if (accept) begin
        pend_q     <= 1'b1;
        pend_tgt_q <= req_target;
        pend_val_q <= cfg_wdata;
      end else if (commit) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign wr_start   = start_q;
  assign wr_nack    = nack_q;
  assign rsp_valid  = rsp_v_q;
  assign rsp_data   = rsp_q;
  assign chip_addr  = addr_q;
  assign cfg_locked = cfg_lock_q;
  assign id_locked  = id_lock_q;

endmodule

// File: rtl/cda_lock_reg_chk.sv
module cda_lock_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_target,
  input logic       wc_in,
  input logic       cycle_done,
  input logic       wr_start,
  input logic       wr_nack,
  input logic [2:0] chip_addr,
  input logic       cfg_locked,
  input logic       id_locked
);

  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_start && wr_nack));

  p_start_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(req_valid && req_write));

  p_addr_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> ($stable(chip_addr) && $stable(cfg_locked)));

  p_cfg_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> (cfg_locked && $stable(chip_addr)));

  p_cfg_locked_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_target && cfg_locked && soft_rst_n) |=> wr_nack);

  p_wc_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && wc_in && soft_rst_n) |=> (wr_nack && !wr_start));

  p_id_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_locked |=> id_locked);

  p_id_relock_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_target && id_locked && soft_rst_n) |=> wr_nack);

  p_read_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (!wr_start && !wr_nack));

endmodule

bind cda_lock_reg cda_lock_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst_n (soft_rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_target (req_target),
  .wc_in      (wc_in),
  .cycle_done (cycle_done),
  .wr_start   (wr_start),
  .wr_nack    (wr_nack),
  .chip_addr  (chip_addr),
  .cfg_locked (cfg_locked),
  .id_locked  (id_locked)
);

// File: tb/sim_cda_lock_reg.sv
module sim_cda_lock_reg;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_target = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic wc_in = 1'b0, cycle_done = 1'b0;

  logic wr_start, wr_nack, rsp_valid, cfg_locked, id_locked;
  logic [7:0] rsp_data;
  logic [2:0] chip_addr;
  logic p_start, p_nack, p_rsp_valid, p_cfg_locked, p_id_locked;
  logic [7:0] p_rsp_data;
  logic [2:0] p_chip_addr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cda_lock_reg u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_target(req_target), .cfg_wdata(cfg_wdata),
    .wc_in(wc_in), .cycle_done(cycle_done), .wr_start(wr_start), .wr_nack(wr_nack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .chip_addr(chip_addr),
    .cfg_locked(cfg_locked), .id_locked(id_locked));

  cda_lock_reg #(.PRESET_EN(1'b1), .PRESET_ADDR(3'b101)) u1 (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_target(req_target), .cfg_wdata(cfg_wdata),
    .wc_in(wc_in), .cycle_done(cycle_done), .wr_start(p_start), .wr_nack(p_nack),
    .rsp_valid(p_rsp_valid), .rsp_data(p_rsp_data), .chip_addr(p_chip_addr),
    .cfg_locked(p_cfg_locked), .id_locked(p_id_locked));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_req(logic w, logic t, logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_target = t; cfg_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cycle_done = 1'b1;
    @(posedge clk); #1; cycle_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 addr", {5'b0, chip_addr}, 8'h00);
    chk("R1 cfg lock", {7'b0, cfg_locked}, 8'h00);
    chk("R1 id lock", {7'b0, id_locked}, 8'h00);
    chk("R1 preset addr", {5'b0, p_chip_addr}, 8'h05);
    chk("R1 preset lock", {7'b0, p_cfg_locked}, 8'h01);
  endtask

  task automatic t_read_cfg();
    drive_req(1'b0, 1'b0, 4'h0);
    chk("R2 valid", {7'b0, rsp_valid}, 8'h01);
    chk("R2 data", rsp_data, 8'h00);
    chk("R2 preset data", p_rsp_data, 8'h0B);
    chk("R12 read no pulse", {6'b0, wr_start, wr_nack}, 8'h00);
  endtask

  task automatic t_write_cfg();
    drive_req(1'b1, 1'b0, 4'h6);
    chk("R3 start", {6'b0, wr_start, wr_nack}, 8'h02);
    chk("R4 preset refuses", {6'b0, p_start, p_nack}, 8'h01);
    chk("R3 old addr held", {4'b0, chip_addr, cfg_locked}, 8'h00);
    drive_req(1'b1, 1'b0, 4'h2);
    chk("R9 busy nack", {6'b0, wr_start, wr_nack}, 8'h01);
    pulse_done();
    chk("R3 committed", {4'b0, chip_addr, cfg_locked}, 8'h06);
    chk("R11 preset unchanged", {4'b0, p_chip_addr, p_cfg_locked}, 8'h0B);
    drive_req(1'b0, 1'b0, 4'h0);
    chk("R2 read new", rsp_data, 8'h06);
  endtask

  task automatic t_idle_done();
    pulse_done();
    @(negedge clk);
    chk("R11 idle done", {4'b0, chip_addr, cfg_locked}, 8'h06);
  endtask

  task automatic t_wc();
    @(negedge clk); wc_in = 1'b1;
    drive_req(1'b1, 1'b0, 4'hA);
    chk("R5 cfg nack", {6'b0, wr_start, wr_nack}, 8'h01);
    drive_req(1'b1, 1'b1, 4'h0);
    chk("R5 lock nack", {6'b0, wr_start, wr_nack}, 8'h01);
    pulse_done();
    chk("R5 addr kept", {4'b0, chip_addr, cfg_locked}, 8'h06);
    chk("R5 id kept", {7'b0, id_locked}, 8'h00);
    @(negedge clk); wc_in = 1'b0;
  endtask

  task automatic t_soft();
    drive_req(1'b1, 1'b0, 4'h8);
    chk("R10 accepted", {6'b0, wr_start, wr_nack}, 8'h02);
    @(negedge clk); soft_rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R10 pulses cleared", {6'b0, wr_start, wr_nack}, 8'h00);
    @(negedge clk); soft_rst_n = 1'b1;
    pulse_done();
    chk("R10 write dropped", {4'b0, chip_addr, cfg_locked}, 8'h06);
  endtask

  task automatic t_lock_cfg();
    drive_req(1'b1, 1'b0, 4'hF);
    chk("R3 lock write", {6'b0, wr_start, wr_nack}, 8'h02);
    pulse_done();
    chk("R3 locked value", {4'b0, chip_addr, cfg_locked}, 8'h0F);
    drive_req(1'b1, 1'b0, 4'h2);
    chk("R4 locked nack", {6'b0, wr_start, wr_nack}, 8'h01);
    pulse_done();
    chk("R4 unchanged", {4'b0, chip_addr, cfg_locked}, 8'h0F);
  endtask

  task automatic t_id();
    drive_req(1'b0, 1'b1, 4'h0);
    chk("R8 unlocked status", rsp_data, 8'h00);
    drive_req(1'b1, 1'b1, 4'h0);
    chk("R6 start", {6'b0, wr_start, wr_nack}, 8'h02);
    chk("R6 not yet", {7'b0, id_locked}, 8'h00);
    pulse_done();
    chk("R6 locked", {7'b0, id_locked}, 8'h01);
    drive_req(1'b0, 1'b1, 4'h0);
    chk("R8 locked status", rsp_data, 8'h01);
    drive_req(1'b1, 1'b1, 4'h0);
    chk("R7 relock nack", {6'b0, wr_start, wr_nack}, 8'h01);
    @(negedge clk); soft_rst_n = 1'b0;
    @(negedge clk); soft_rst_n = 1'b1;
    chk("R10 id kept", {7'b0, id_locked}, 8'h01);
    chk("R10 cfg kept", {4'b0, chip_addr, cfg_locked}, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_cfg();
    t_write_cfg();
    t_idle_done();
    t_wc();
    t_soft();
    t_lock_cfg();
    t_id();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule